// File: doc/BRIEF.md
# Codec Operating-Mode and Power-Down Supervisor

This block watches the serial-side timing pins of a PCM voice codec and decides which of four operating states the codec is in: full-duplex, transmit-only half-channel, receive-only half-channel, or powered down. All decisions come from activity sensing in a free-running reference clock domain. A pin counts as clocking when it has toggled recently, and as held when it has stayed still for a parameterised window.

Two input pins do double duty. The receive master clock pin also acts as a power-down command when it is held at a static high level. The receive bit clock pin also acts as a clock-select strap when it is static; in that case the transmit bit clock serves both directions. The block reports which master clock and which receive bit clock to use. It enables the receive data path only in the states that accept receive data. It keeps the transmit data and timeslot drivers disabled after every wake-up until the transmit sync has pulsed twice.

Changes of state between live modes take effect only at a frame sync rising edge, so a PCM word in flight is never cut short. Entry into power-down, whether by pin or by timeout, is immediate.

Top module: `codec_mode_ctrl`

## Requirements
- R1: After reset, mode_o is 2'b00 (power-down), pdn_o is 1, and tx_out_en_o, rx_accept_o, mclk_sel_o and rx_bclk_sel_o are 0.
- R2: A monitored pin is treated as clocking while an edge of it has been seen within the last ACT_WIN reference cycles (after the synchroniser), and as held once ACT_WIN cycles pass without an edge; a single isolated edge makes a pin clocking only briefly.
- R3: With both frame syncs clocking and the power-down pin not held high, mode_o becomes 2'b01 (full-duplex) and rx_accept_o is 1.
- R4: With the transmit sync clocking and the receive sync held, mode_o becomes 2'b10 (transmit half-channel) and rx_accept_o is 0, so receive data is ignored.
- R5: With the receive sync clocking and the transmit sync held, mode_o becomes 2'b11 (receive half-channel) and tx_out_en_o is 0.
- R6: With both frame syncs held, the mode is kept until TIMEOUT_CYC reference cycles have passed since the last edge of either sync, and then becomes power-down (mode_o 2'b00, pdn_o 1).
- R7: A static high level on rx_mclk_pdn (held for ACT_WIN cycles) forces power-down even while the frame syncs run.
- R8: Power-down is left only when rx_mclk_pdn is low or clocking and at least one frame sync is clocking; a static high level keeps the block powered down.
- R9: After leaving power-down, tx_out_en_o stays 0 until two rising edges of tx_sync have been seen with the mode out of power-down (the edge that caused the wake-up does not count); it is 1 only in full-duplex or transmit half-channel mode.
- R10: mclk_sel_o is 1 (use the receive master clock) only in receive half-channel mode while rx_mclk_pdn is clocking; otherwise it is 0 (use the transmit master clock).
- R11: rx_bclk_sel_o is 1 (use the receive bit clock) while rx_bclk_cs is clocking and 0 (transmit bit clock serves both directions) while it is static.
- R12: A change of mode into any state other than power-down takes effect only in the second reference cycle after a rising edge of either frame sync is seen past the synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for activity timing |
| rst_n | input | 1 | Active-low reset |
| tx_sync | input | 1 | Transmit frame sync pin |
| rx_sync | input | 1 | Receive frame sync pin |
| rx_mclk_pdn | input | 1 | Receive master clock, static high means power-down |
| rx_bclk_cs | input | 1 | Receive bit clock, static level is a clock-select strap |
| mode_o | output | 2 | 00 power-down, 01 full-duplex, 10 transmit half, 11 receive half |
| pdn_o | output | 1 | High while powered down |
| mclk_sel_o | output | 1 | 1 selects the receive master clock as internal master clock |
| rx_bclk_sel_o | output | 1 | 1 selects the receive bit clock for the receive direction |
| tx_out_en_o | output | 1 | Enable for transmit data and timeslot drivers |
| rx_accept_o | output | 1 | High when receive serial data is to be used |

## Verification
The assertions take for granted that the monitored pins are slow enough against the reference clock for every toggle to pass the synchroniser, and that ACT_WIN is shorter than TIMEOUT_CYC, so a live frame sync always keeps the idle timer from expiring. The stimulus meets both by changing pins only on the falling reference edge, running frame syncs with a 12-cycle period and a 2-cycle pulse against a 16-cycle window, and toggling clock pins every cycle. Power-down is approached both by stopping the syncs and by parking the shared pin high, and the shared pin is then released in turn to a low level and to a running clock.

// File: rtl/codec_mode_pkg.sv
package codec_mode_pkg;

  typedef enum logic [1:0] {
    MODE_PDN  = 2'b00,
    MODE_FULL = 2'b01,
    MODE_TXH  = 2'b10,
    MODE_RXH  = 2'b11
  } op_mode_e;

  // Monitored pin slots
  localparam int NUM_MON = 4;
  localparam int IDX_TXS = 0;
  localparam int IDX_RXS = 1;
  localparam int IDX_RMC = 2;
  localparam int IDX_RBC = 3;

  localparam logic [NUM_MON-1:0] SYNC_MASK = 4'b0011;
  localparam logic [NUM_MON-1:0] PDN_MASK  = 4'b0100;

  localparam logic [1:0] TX_WAKE_PULSES = 2'd2;

  // Target state from the sensed pin activity
  function automatic op_mode_e pick_mode(input logic pin_off,
                                         input logic tx_live,
                                         input logic rx_live,
                                         input logic expired,
                                         input op_mode_e cur);
    op_mode_e m;
    if (pin_off)                 m = MODE_PDN;
    else if (tx_live && rx_live) m = MODE_FULL;
    else if (tx_live)            m = MODE_TXH;
    else if (rx_live)            m = MODE_RXH;
    else if (expired)            m = MODE_PDN;
    else                         m = cur;
    return m;
  endfunction

  function automatic logic tx_gate_open(input op_mode_e m, input logic [1:0] seen);
    return ((m == MODE_FULL) || (m == MODE_TXH)) && (seen == TX_WAKE_PULSES);
  endfunction

  function automatic logic rx_path_on(input op_mode_e m);
    return (m == MODE_FULL) || (m == MODE_RXH);
  endfunction

endpackage

// File: rtl/cmc_activity.sv
module cmc_activity #(
  parameter int SYNC_STAGES = 2,
  parameter int ACT_WIN     = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic edge_o,
  output logic rise_o,
  output logic active_o
);
  localparam int CW = $clog2(ACT_WIN + 1);
  localparam logic [CW-1:0] WIN_V = CW'(ACT_WIN);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [CW-1:0]          quiet_q;

  assign level_o  = sync_q[SYNC_STAGES-1];
  assign edge_o   = level_o ^ prev_q;
  assign rise_o   = level_o & ~prev_q;
  assign active_o = (quiet_q != WIN_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      quiet_q <= WIN_V;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= level_o;
      if (edge_o)
        quiet_q <= '0;
      else if (quiet_q != WIN_V)
        quiet_q <= quiet_q + CW'(1);
    end
  end
endmodule

// File: rtl/cmc_idle_timer.sv
module cmc_idle_timer #(
  parameter int TIMEOUT_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  output logic expired_o
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] LIM = TW'(TIMEOUT_CYC);

  logic [TW-1:0] cnt_q;

  assign expired_o = (cnt_q == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (kick_i)
      cnt_q <= '0;
    else if (!expired_o)
      cnt_q <= cnt_q + TW'(1);
  end
endmodule

// File: rtl/cmc_mode_fsm.sv
module cmc_mode_fsm
  import codec_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pin_off_i,
  input  logic     tx_live_i,
  input  logic     rx_live_i,
  input  logic     expired_i,
  input  logic     boundary_i,
  output op_mode_e mode_o,
  output logic     commit_slot_o
);
  op_mode_e mode_q;
  op_mode_e target;
  logic     boundary_q;

  // One cycle after the sync edge the activity flags already reflect it
  assign commit_slot_o = boundary_q;
  assign mode_o        = mode_q;
  assign target        = pick_mode(pin_off_i, tx_live_i, rx_live_i, expired_i, mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_PDN;
      boundary_q <= 1'b0;
    end else begin
      boundary_q <= boundary_i;
      if (target == MODE_PDN)
        mode_q <= MODE_PDN;
      else if (boundary_q)
        mode_q <= target;
    end
  end
endmodule

// File: rtl/cmc_tx_gate.sv
module cmc_tx_gate
  import codec_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  op_mode_e mode_i,
  input  logic     tx_rise_i,
  output logic     open_o
);
  logic [1:0] seen_q;

  assign open_o = tx_gate_open(mode_i, seen_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      seen_q <= '0;
    else if (mode_i == MODE_PDN)
      seen_q <= '0;
    else if (tx_rise_i && (seen_q != TX_WAKE_PULSES))
      seen_q <= seen_q + 2'd1;
  end
endmodule

// File: rtl/codec_mode_ctrl.sv
module codec_mode_ctrl
  import codec_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ACT_WIN     = 16,
  parameter int TIMEOUT_CYC = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_sync,
  input  logic       rx_sync,
  input  logic       rx_mclk_pdn,
  input  logic       rx_bclk_cs,
  output logic [1:0] mode_o,
  output logic       pdn_o,
  output logic       mclk_sel_o,
  output logic       rx_bclk_sel_o,
  output logic       tx_out_en_o,
  output logic       rx_accept_o
);
  logic [NUM_MON-1:0] mon_pins;
  logic [NUM_MON-1:0] lvl_v, edge_v, rise_v, act_v;

  assign mon_pins = {rx_bclk_cs, rx_mclk_pdn, rx_sync, tx_sync};

  for (genvar g = 0; g < NUM_MON; g++) begin : g_mon
    cmc_activity #(
      .SYNC_STAGES(SYNC_STAGES),
      .ACT_WIN    (ACT_WIN)
    ) u_act (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (mon_pins[g]),
      .level_o (lvl_v[g]),
      .edge_o  (edge_v[g]),
      .rise_o  (rise_v[g]),
      .active_o(act_v[g])
    );
  end

  // Named internal events
  logic tx_live, rx_live, pin_off, sync_kick, boundary, tx_rise;
  logic idle_expired, commit_slot;
  op_mode_e mode_q;

  assign tx_live   = act_v[IDX_TXS];
  assign rx_live   = act_v[IDX_RXS];
  assign pin_off   = |(lvl_v & ~act_v & PDN_MASK);
  assign sync_kick = |(edge_v & SYNC_MASK);
  assign boundary  = |(rise_v & SYNC_MASK);
  assign tx_rise   = rise_v[IDX_TXS];

  cmc_idle_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .kick_i   (sync_kick),
    .expired_o(idle_expired)
  );

  cmc_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_off_i    (pin_off),
    .tx_live_i    (tx_live),
    .rx_live_i    (rx_live),
    .expired_i    (idle_expired),
    .boundary_i   (boundary),
    .mode_o       (mode_q),
    .commit_slot_o(commit_slot)
  );

  cmc_tx_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode_q),
    .tx_rise_i(tx_rise),
    .open_o   (tx_out_en_o)
  );

  assign mode_o        = mode_q;
  assign pdn_o         = (mode_q == MODE_PDN);
  assign rx_accept_o   = rx_path_on(mode_q);
  assign mclk_sel_o    = (mode_q == MODE_RXH) && act_v[IDX_RMC];
  assign rx_bclk_sel_o = act_v[IDX_RBC];
endmodule

// File: rtl/codec_mode_ctrl_chk.sv
module codec_mode_ctrl_chk
  import codec_mode_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       pin_off,
  input logic       tx_live,
  input logic       rx_live,
  input logic       expired,
  input logic       commit_slot,
  input logic       tx_rise,
  input logic       tx_open
);
  p_commit_boundary_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode != $past(mode)) && (mode != MODE_PDN)) |-> $past(commit_slot));

  p_pin_pdn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pin_off |=> (mode == MODE_PDN));

  p_timeout_pdn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !tx_live && !rx_live) |=> (mode == MODE_PDN));

  p_wake_cond_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(mode) == MODE_PDN) && (mode != MODE_PDN)) |->
      (!$past(pin_off) && ($past(tx_live) || $past(rx_live))));

  p_tx_open_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_open) |-> ($past(tx_rise) || (mode != $past(mode))));
endmodule

bind codec_mode_ctrl codec_mode_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode_q),
  .pin_off    (pin_off),
  .tx_live    (tx_live),
  .rx_live    (rx_live),
  .expired    (idle_expired),
  .commit_slot(commit_slot),
  .tx_rise    (tx_rise),
  .tx_open    (tx_out_en_o)
);

// File: tb/codec_mode_ctrl_tb.sv
module codec_mode_ctrl_tb;
  localparam int WIN = 16;
  localparam int TMO = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic tx_sync, rx_sync, rx_mclk_pdn, rx_bclk_cs;
  logic [1:0] mode_o;
  logic pdn_o, mclk_sel_o, rx_bclk_sel_o, tx_out_en_o, rx_accept_o;

  codec_mode_ctrl #(.SYNC_STAGES(2), .ACT_WIN(WIN), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_sync(tx_sync), .rx_sync(rx_sync),
    .rx_mclk_pdn(rx_mclk_pdn), .rx_bclk_cs(rx_bclk_cs), .mode_o(mode_o),
    .pdn_o(pdn_o), .mclk_sel_o(mclk_sel_o), .rx_bclk_sel_o(rx_bclk_sel_o),
    .tx_out_en_o(tx_out_en_o), .rx_accept_o(rx_accept_o));

  // Pin generators, all changes on the falling edge
  logic run_ts = 0, run_rs = 0, run_mr = 0, run_br = 0;
  logic lvl_mr = 0, lvl_br = 0;
  int phase = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      phase <= 0; tx_sync <= 0; rx_sync <= 0; rx_mclk_pdn <= 0; rx_bclk_cs <= 0;
    end else begin
      phase       <= (phase == 11) ? 0 : phase + 1;
      tx_sync     <= run_ts && (phase < 2);
      rx_sync     <= run_rs && (phase < 2);
      rx_mclk_pdn <= run_mr ? ~rx_mclk_pdn : lvl_mr;
      rx_bclk_cs  <= run_br ? ~rx_bclk_cs  : lvl_br;
    end
  end

  // Scoreboard
  typedef struct {string tag; logic [6:0] exp; logic [6:0] msk;} item_t;
  item_t sb_q[$];
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  localparam logic [6:0] M_MODE = 7'b1100000, M_PDN = 7'b0010000, M_TX = 7'b0001000,
                         M_RX = 7'b0000100, M_MS = 7'b0000010, M_BS = 7'b0000001;

  function automatic logic [6:0] mk(logic [1:0] m, logic p, logic t, logic r, logic ms, logic bs);
    return {m, p, t, r, ms, bs};
  endfunction

  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [6:0] obs;
      it  = sb_q.pop_front();
      obs = {mode_o, pdn_o, tx_out_en_o, rx_accept_o, mclk_sel_o, rx_bclk_sel_o};
      n_checks++;
      if (((obs ^ it.exp) & it.msk) != 7'd0) begin
        n_fail++;
        $display("FAIL %s: got %b expected %b (mask %b)", it.tag, obs, it.exp, it.msk);
      end
    end
  end

  task automatic expect_st(string tag, logic [6:0] e, logic [6:0] m);
    @(posedge clk); #1;
    sb_q.push_back('{tag, e, m});
    @(posedge clk);
  endtask

  task automatic direct_check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wait_mode(logic [1:0] m, int lim);
    int k = 0;
    while (mode_o != m && k < lim) begin @(posedge clk); k++; end
  endtask

  // R12 watcher: cycles from a pin-level sync rise to a mode change
  logic ts_q = 0, rs_q = 0;
  logic [1:0] mode_prev = 2'b00;
  int since_rise = 100, r12_seen = 0, r12_bad = 0;
  always @(negedge clk) begin
    ts_q <= tx_sync; rs_q <= rx_sync;
    if ((tx_sync && !ts_q) || (rx_sync && !rs_q)) since_rise <= 0;
    else since_rise <= since_rise + 1;
    mode_prev <= mode_o;
    if (rst_n && (mode_o != mode_prev) && (mode_o != 2'b00)) begin
      r12_seen <= r12_seen + 1;
      if (since_rise > 6) r12_bad <= r12_bad + 1;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(4);
    expect_st("R1 reset state", mk(2'b00, 1, 0, 0, 0, 0), 7'h7F);

    // Wake with both syncs
    run_ts = 1; run_rs = 1;
    wait_mode(2'b01, 200);
    expect_st("R9 gated right after wake", mk(2'b01, 0, 0, 1, 0, 0), M_MODE | M_TX);
    @(posedge tx_sync); wait_cyc(6);
    expect_st("R9 gated after first tx sync", mk(2'b01, 0, 0, 1, 0, 0), M_MODE | M_TX);
    @(posedge tx_sync); wait_cyc(6);
    expect_st("R3 full duplex, R9 open", mk(2'b01, 0, 1, 1, 0, 0), 7'h7F);

    // Receive bit clock running vs static
    run_br = 1; wait_cyc(30);
    expect_st("R11 rx bit clock used", mk(2'b01, 0, 1, 1, 0, 1), M_BS | M_MODE);
    run_br = 0; lvl_br = 0; wait_cyc(40);
    expect_st("R11 static strap selects tx bit clock", mk(2'b01, 0, 1, 1, 0, 0), M_BS);

    // Single isolated edge
    lvl_br = 1; wait_cyc(6);
    expect_st("R2 edge within window", mk(2'b01, 0, 1, 1, 0, 1), M_BS);
    wait_cyc(40);
    expect_st("R2 held after window", mk(2'b01, 0, 1, 1, 0, 0), M_BS);
    lvl_br = 0; wait_cyc(40);

    // Transmit half-channel
    run_rs = 0;
    wait_mode(2'b10, 200); wait_cyc(2);
    expect_st("R4 tx half, rx ignored", mk(2'b10, 0, 1, 0, 0, 0), M_MODE | M_PDN | M_TX | M_RX);

    // Back to full duplex, receive master clock running
    run_rs = 1; wait_mode(2'b01, 200);
    run_mr = 1; wait_cyc(30);
    expect_st("R3 back to full, R10 tx master clock", mk(2'b01, 0, 1, 1, 0, 0), M_MODE | M_RX | M_MS);

    // Receive half-channel
    run_ts = 0; wait_mode(2'b11, 200); wait_cyc(10);
    expect_st("R5 rx half, tx closed, R10 rx mclk", mk(2'b11, 0, 0, 1, 1, 0), M_MODE | M_PDN | M_TX | M_RX | M_MS);
    run_mr = 0; lvl_mr = 0; wait_cyc(40);
    expect_st("R10 rx mclk idle falls back", mk(2'b11, 0, 0, 1, 0, 0), M_MODE | M_MS);

    // Timeout power-down
    run_rs = 0; wait_cyc(150);
    expect_st("R6 not yet timed out", mk(2'b11, 0, 0, 1, 0, 0), M_MODE | M_PDN);
    wait_cyc(250);
    expect_st("R6 timed out to power-down", mk(2'b00, 1, 0, 0, 0, 0), M_MODE | M_PDN | M_TX | M_RX);

    // Pin power-down
    run_ts = 1; run_rs = 1; wait_mode(2'b01, 200);
    lvl_mr = 1; wait_cyc(40);
    expect_st("R7 static high forces power-down", mk(2'b00, 1, 0, 0, 0, 0), M_MODE | M_PDN | M_TX);
    wait_cyc(100);
    expect_st("R8 stays down while pin high", mk(2'b00, 1, 0, 0, 0, 0), M_MODE | M_PDN);
    lvl_mr = 0; wait_mode(2'b01, 200); wait_cyc(2);
    expect_st("R8 wake with pin low", mk(2'b01, 0, 0, 1, 0, 0), M_MODE | M_PDN);
    lvl_mr = 1; wait_cyc(40);
    expect_st("R8 down again", mk(2'b00, 1, 0, 0, 0, 0), M_MODE | M_PDN);
    run_mr = 1; wait_cyc(60);
    expect_st("R8 wake with pin clocking", mk(2'b01, 0, 0, 1, 0, 0), M_MODE | M_PDN);

    direct_check("R12 mode changes seen", (r12_seen > 0) ? 1 : 0, 1);
    direct_check("R12 changes away from sync boundary", r12_bad, 0);

    done = 1;
    wait_cyc(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule